// File: doc/BRIEF.md
# Switchable Program Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and three cartridge memories: program ROM, pattern memory and save RAM. For every CPU access it registers a physical address, a chip select and a write enable for the one memory that the access targets. It also returns the byte that the selected memory supplies. The program ROM is split into 16 KB banks. The lower program window at 0x8000 shows a bank chosen at run time. The upper window at 0xC000 always shows the last bank. Pattern memory and save RAM are reached through fixed windows, with no translation beyond subtracting the window base.

The program ROM cannot be written. A CPU write anywhere at or above 0x8000 therefore acts as a bank-select command instead of a memory write. The written byte, reduced modulo the bank count, becomes the new lower-window bank. The bank count is a parameter from 1 to 256 and does not need to be a power of two. An access in the gap 0x2000–0x5FFF selects nothing and raises an error strobe.

Top module: `bank_mapper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every chip select, every write enable and `err` are low and `cpu_rdata` is 0x00. The lower program window starts on bank 0.
- R2: An access to 0x0000–0x1FFF asserts `pat_cs` one cycle later with `pat_addr` equal to the CPU address bits [12:0]. `pat_we` is high for a write and low for a read.
- R3: An access to 0x6000–0x7FFF asserts `sav_cs` one cycle later with `sav_addr` equal to the CPU address minus 0x6000. `sav_we` is high for a write and low for a read.
- R4: A read of 0x8000–0xBFFF asserts `prg_cs` one cycle later with `prg_addr` equal to current bank × 0x4000 + (address − 0x8000).
- R5: A read of 0xC000–0xFFFF asserts `prg_cs` one cycle later with `prg_addr` equal to (NUM_BANKS − 1) × 0x4000 + (address − 0xC000), whatever bank is selected.
- R6: A write at or above 0x8000 asserts no chip select and no `err`. It loads the bank with the written byte modulo NUM_BANKS, and this holds for counts that are not powers of two (default 6, so 0xFF selects bank 3).
- R7: A lower-window read issued in the cycle right after a bank-select write already uses the new bank.
- R8: A read or write to 0x2000–0x5FFF raises `err` for exactly one cycle per access. It asserts no chip select, returns 0x00 on `cpu_rdata` and leaves the bank unchanged.
- R9: In the cycle after a read, `cpu_rdata` carries the byte that the selected memory returns for the registered address. In any cycle after an idle cycle or a write, `cpu_rdata` is 0x00. During a write, `mem_wdata` carries the CPU byte with the same one-cycle delay as the strobes.
- R10: When `cpu_rd` and `cpu_wr` are both high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_rdata | output | 8 | Read byte returned to the CPU |
| err | output | 1 | Unmapped or invalid access strobe |
| prg_cs | output | 1 | Program ROM select |
| prg_addr | output | BANK_W+14 | Physical program ROM address |
| prg_rdata | input | 8 | Program ROM read byte |
| pat_cs | output | 1 | Pattern memory select |
| pat_we | output | 1 | Pattern memory write enable |
| pat_addr | output | 13 | Pattern memory address |
| pat_rdata | input | 8 | Pattern memory read byte |
| sav_cs | output | 1 | Save RAM select |
| sav_we | output | 1 | Save RAM write enable |
| sav_addr | output | 13 | Save RAM address |
| sav_rdata | input | 8 | Save RAM read byte |
| mem_wdata | output | 8 | Registered write byte for the memories |

## Verification
The only hidden state is the selected bank. If it is wrong, the upper bits of `prg_addr` on the next lower-window read show it, and `cpu_rdata` returns a different ROM byte one cycle after that read. Upper-window reads must keep returning the last bank even after many selects. A wrong modulo therefore shows up on the first read that follows a write of a byte at or above the bank count. The reference model checks every cycle against a byte-level model of all three memories. Because of that, a bad address offset, a missed write enable or a stray select shows as a data mismatch within one or two cycles.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int WIN_W  = 14;  // offset bits inside a 16 KB program bank
  localparam int PAT_AW = 13;  // pattern memory address bits
  localparam int SAV_AW = 13;  // save RAM address bits

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PAT,
    RG_SAV,
    RG_PRG_LO,
    RG_PRG_HI
  } region_t;

  function automatic int bank_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
(
  input  logic [15:0] addr,
  output region_t     region
);
  always_comb begin
    unique case (addr[15:13])
      3'b000:                 region = RG_PAT;
      3'b011:                 region = RG_SAV;
      3'b100, 3'b101:         region = RG_PRG_LO;
      3'b110, 3'b111:         region = RG_PRG_HI;
      default:                region = RG_NONE;
    endcase
  end
endmodule

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
  parameter int NUM_BANKS = 6,
  parameter int BANK_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [7:0]        data,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_next;

  generate
    if (NUM_BANKS == 1) begin : g_single
      assign bank_next = '0;
    end else if ((NUM_BANKS & (NUM_BANKS - 1)) == 0) begin : g_pow2
      assign bank_next = data[BANK_W-1:0];
    end else begin : g_mod
      logic [8:0] rem;
      assign rem       = {1'b0, data} % 9'(NUM_BANKS);
      assign bank_next = rem[BANK_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= bank_next;
  end
endmodule

// File: rtl/mapper_rdata_mux.sv
module mapper_rdata_mux
  import mapper_pkg::*;
(
  input  region_t    src,
  input  logic [7:0] prg_rdata,
  input  logic [7:0] pat_rdata,
  input  logic [7:0] sav_rdata,
  output logic [7:0] rdata
);
  always_comb begin
    unique case (src)
      RG_PAT:               rdata = pat_rdata;
      RG_SAV:               rdata = sav_rdata;
      RG_PRG_LO, RG_PRG_HI: rdata = prg_rdata;
      default:              rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter  int NUM_BANKS = 6,
  localparam int BANK_W    = bank_bits(NUM_BANKS),
  localparam int PRG_AW    = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic              err,
  output logic              prg_cs,
  output logic [PRG_AW-1:0] prg_addr,
  input  logic [7:0]        prg_rdata,
  output logic              pat_cs,
  output logic              pat_we,
  output logic [PAT_AW-1:0] pat_addr,
  input  logic [7:0]        pat_rdata,
  output logic              sav_cs,
  output logic              sav_we,
  output logic [SAV_AW-1:0] sav_addr,
  input  logic [7:0]        sav_rdata,
  output logic [7:0]        mem_wdata
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  region_t           region;
  region_t           rd_src;
  logic              active;
  logic              is_prg;
  logic              bank_load;
  logic [BANK_W-1:0] cur_bank;

  mapper_decode u_decode (
    .addr   (cpu_addr),
    .region (region)
  );

  assign active    = cpu_rd | cpu_wr;
  assign is_prg    = (region == RG_PRG_LO) || (region == RG_PRG_HI);
  assign bank_load = cpu_wr && is_prg;

  mapper_bank_reg #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .load (bank_load),
    .data (cpu_wdata),
    .bank (cur_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err       <= 1'b0;
      prg_cs    <= 1'b0;
      prg_addr  <= '0;
      pat_cs    <= 1'b0;
      pat_we    <= 1'b0;
      pat_addr  <= '0;
      sav_cs    <= 1'b0;
      sav_we    <= 1'b0;
      sav_addr  <= '0;
      mem_wdata <= '0;
      rd_src    <= RG_NONE;
    end else begin
      err       <= 1'b0;
      prg_cs    <= 1'b0;
      pat_cs    <= 1'b0;
      pat_we    <= 1'b0;
      sav_cs    <= 1'b0;
      sav_we    <= 1'b0;
      rd_src    <= RG_NONE;
      mem_wdata <= cpu_wdata;
      pat_addr  <= cpu_addr[PAT_AW-1:0];
      sav_addr  <= cpu_addr[SAV_AW-1:0];
      prg_addr  <= {(region == RG_PRG_HI) ? LAST_BANK : cur_bank,
                    cpu_addr[WIN_W-1:0]};
      if (active) begin
        unique case (region)
          RG_PAT: begin
            pat_cs <= 1'b1;
            pat_we <= cpu_wr;
            if (!cpu_wr) rd_src <= RG_PAT;
          end
          RG_SAV: begin
            sav_cs <= 1'b1;
            sav_we <= cpu_wr;
            if (!cpu_wr) rd_src <= RG_SAV;
          end
          RG_PRG_LO, RG_PRG_HI: begin
            if (!cpu_wr) begin
              prg_cs <= 1'b1;
              rd_src <= region;
            end
          end
          default: err <= 1'b1;
        endcase
      end
    end
  end

  mapper_rdata_mux u_rmux (
    .src       (rd_src),
    .prg_rdata (prg_rdata),
    .pat_rdata (pat_rdata),
    .sav_rdata (sav_rdata),
    .rdata     (cpu_rdata)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int NUM_BANKS = 6,
  parameter int PRG_AW    = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              err,
  input logic              prg_cs,
  input logic [PRG_AW-1:0] prg_addr,
  input logic              pat_cs,
  input logic              pat_we,
  input logic [12:0]       pat_addr,
  input logic              sav_cs,
  input logic              sav_we,
  input logic [12:0]       sav_addr
);
  localparam int BW = PRG_AW - 14;

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prg_cs, pat_cs, sav_cs, err}));

  // R2
  pat_route_chk: assert property (@(posedge clk) disable iff (rst)
    pat_cs |-> (pat_addr == $past(cpu_addr[12:0]) && pat_we == $past(cpu_wr)
                && $past(cpu_addr[15:13]) == 3'b000));

  // R3
  sav_route_chk: assert property (@(posedge clk) disable iff (rst)
    sav_cs |-> (sav_addr == $past(cpu_addr[12:0]) && sav_we == $past(cpu_wr)
                && $past(cpu_addr[15:13]) == 3'b011));

  // R4
  bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    prg_cs |-> (int'(prg_addr[PRG_AW-1:14]) < NUM_BANKS));

  // R5
  top_window_chk: assert property (@(posedge clk) disable iff (rst)
    (prg_cs && $past(cpu_addr[15:14]) == 2'b11)
      |-> (prg_addr[PRG_AW-1:14] == BW'(NUM_BANKS - 1)));

  // R6
  bank_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_wr) && $past(cpu_addr[15]))
      |-> !(prg_cs || pat_cs || sav_cs || err));

  // R8
  err_match_chk: assert property (@(posedge clk) disable iff (rst)
    err == ($past(cpu_rd || cpu_wr) &&
            ($past(cpu_addr[15:13]) == 3'b001 || $past(cpu_addr[15:13]) == 3'b010)));
endmodule

bind bank_mapper bank_mapper_chk #(
  .NUM_BANKS (NUM_BANKS),
  .PRG_AW    (PRG_AW)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cpu_rd   (cpu_rd),
  .cpu_wr   (cpu_wr),
  .err      (err),
  .prg_cs   (prg_cs),
  .prg_addr (prg_addr),
  .pat_cs   (pat_cs),
  .pat_we   (pat_we),
  .pat_addr (pat_addr),
  .sav_cs   (sav_cs),
  .sav_we   (sav_we),
  .sav_addr (sav_addr)
);

// File: tb/test_bank_mapper.sv
`timescale 1ns/1ps
module test_bank_mapper;
  localparam int NB     = 6;
  localparam int PRG_AW = 17;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_rd = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [7:0]        cpu_rdata;
  logic              err;
  logic              prg_cs;
  logic [PRG_AW-1:0] prg_addr;
  logic [7:0]        prg_rdata;
  logic              pat_cs, pat_we, sav_cs, sav_we;
  logic [12:0]       pat_addr, sav_addr;
  logic [7:0]        pat_rdata = '0;
  logic [7:0]        sav_rdata = '0;
  logic [7:0]        mem_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bank_mapper #(.NUM_BANKS(NB)) i_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .err(err),
    .prg_cs(prg_cs), .prg_addr(prg_addr), .prg_rdata(prg_rdata),
    .pat_cs(pat_cs), .pat_we(pat_we), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
    .sav_cs(sav_cs), .sav_we(sav_we), .sav_addr(sav_addr), .sav_rdata(sav_rdata),
    .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] rom_byte(input int a);
    return 8'((a * 7 + (a >> 8) * 13 + (a >> 14) * 29 + 5) & 255);
  endfunction

  // memories attached to the block, driven only by its strobes
  logic [7:0] pat_mem [int];
  logic [7:0] sav_mem [int];
  // reference copies, updated by the model
  logic [7:0] ref_pat [int];
  logic [7:0] ref_sav [int];
  int ref_bank = 0;

  assign prg_rdata = rom_byte(int'(prg_addr));

  always @(posedge clk) begin
    if (pat_cs && pat_we) pat_mem[int'(pat_addr)] = mem_wdata;
    if (sav_cs && sav_we) sav_mem[int'(sav_addr)] = mem_wdata;
    #1;
    pat_rdata = pat_mem.exists(int'(pat_addr)) ? pat_mem[int'(pat_addr)] : 8'h00;
    sav_rdata = sav_mem.exists(int'(sav_addr)) ? sav_mem[int'(sav_addr)] : 8'h00;
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
  endtask

  // one access: drive at negedge, model it, compare at next negedge
  task automatic step(input bit rd, input bit wr, input logic [15:0] a,
                      input logic [7:0] d, input string req);
    bit e_prg, e_pat, e_sav, e_err, e_we;
    int e_paddr, e_off;
    logic [7:0] e_rdata;
    bit ok;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    e_prg = 0; e_pat = 0; e_sav = 0; e_err = 0; e_we = wr; e_paddr = 0;
    e_rdata = 8'h00;
    e_off = int'(a) & 16'h1FFF;
    if (rd || wr) begin
      if (a < 16'h2000) begin
        e_pat = 1;
        if (wr) ref_pat[e_off] = d;
        else e_rdata = ref_pat.exists(e_off) ? ref_pat[e_off] : 8'h00;
      end else if (a < 16'h6000) begin
        e_err = 1;
      end else if (a < 16'h8000) begin
        e_sav = 1;
        if (wr) ref_sav[e_off] = d;
        else e_rdata = ref_sav.exists(e_off) ? ref_sav[e_off] : 8'h00;
      end else if (wr) begin
        ref_bank = int'(d) % NB;
      end else begin
        e_prg = 1;
        e_paddr = (a >= 16'hC000) ? (NB - 1) * 16'h4000 + (int'(a) - 16'hC000)
                                  : ref_bank * 16'h4000 + (int'(a) - 16'h8000);
        e_rdata = rom_byte(e_paddr);
      end
    end
    @(negedge clk);
    checks++;
    ok = 1;
    if (prg_cs !== e_prg) begin fail_line(req, "prg_cs", prg_cs, e_prg); ok = 0; end
    if (pat_cs !== e_pat) begin fail_line(req, "pat_cs", pat_cs, e_pat); ok = 0; end
    if (sav_cs !== e_sav) begin fail_line(req, "sav_cs", sav_cs, e_sav); ok = 0; end
    if (err !== e_err)    begin fail_line(req, "err", err, e_err); ok = 0; end
    if (ok && e_prg && int'(prg_addr) != e_paddr)
      fail_line(req, "prg_addr", int'(prg_addr), e_paddr);
    if (ok && e_pat && (int'(pat_addr) != e_off || pat_we !== e_we))
      fail_line(req, "pat_addr/we", {pat_we, pat_addr}, {e_we, e_off[12:0]});
    if (ok && e_sav && (int'(sav_addr) != e_off || sav_we !== e_we))
      fail_line(req, "sav_addr/we", {sav_we, sav_addr}, {e_we, e_off[12:0]});
    if (ok && (e_pat || e_sav) && wr && mem_wdata !== d)
      fail_line(req, "mem_wdata", mem_wdata, d);
    if (cpu_rdata !== e_rdata) fail_line(req, "cpu_rdata", cpu_rdata, e_rdata);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state while held
    if ({prg_cs, pat_cs, sav_cs, err, pat_we, sav_we} !== 6'b0 || cpu_rdata !== 8'h00)
      fail_line("R1", "strobes in reset", {prg_cs, pat_cs, sav_cs, err}, 0);
    rst = 1'b0;
    step(0, 0, 16'h0000, 8'h00, "R1");      // first cycle after reset
    step(1, 0, 16'h8123, 8'h00, "R1");      // bank 0 after reset
    // R2 pattern memory write then read back
    step(0, 1, 16'h0005, 8'hA5, "R2");
    step(1, 0, 16'h0005, 8'h00, "R2");
    step(0, 1, 16'h1FFF, 8'h3C, "R2");
    step(1, 0, 16'h1FFF, 8'h00, "R2");
    // R3 save RAM edges
    step(0, 1, 16'h6000, 8'h11, "R3");
    step(0, 1, 16'h7FFF, 8'h22, "R3");
    step(1, 0, 16'h6000, 8'h00, "R3");
    step(1, 0, 16'h7FFF, 8'h00, "R3");
    // R6 non-power-of-two modulo: 0xFF mod 6 = 3, then R7 read next cycle
    step(0, 1, 16'hFFFF, 8'hFF, "R6");
    step(1, 0, 16'h8000, 8'h00, "R7");
    step(1, 0, 16'hBFFF, 8'h00, "R4");
    // R5 top window stays on last bank
    step(1, 0, 16'hC000, 8'h00, "R5");
    step(1, 0, 16'hFFFF, 8'h00, "R5");
    step(0, 1, 16'h8000, 8'h07, "R6");      // 7 mod 6 = 1
    step(1, 0, 16'h9ABC, 8'h00, "R7");
    step(1, 0, 16'hE000, 8'h00, "R5");
    step(0, 1, 16'hA000, 8'h05, "R6");      // last bank in low window
    step(1, 0, 16'h8001, 8'h00, "R4");
    // R8 unmapped gap: error, no select, bank unchanged
    step(1, 0, 16'h2000, 8'h00, "R8");
    step(0, 1, 16'h5FFF, 8'h02, "R8");
    step(0, 0, 16'h5FFF, 8'h00, "R8");
    step(1, 0, 16'h8010, 8'h00, "R8");
    // R10 read and write together act as a write
    step(1, 1, 16'h8000, 8'h0C, "R10");     // 12 mod 6 = 0
    step(1, 1, 16'h0100, 8'h77, "R10");
    step(1, 0, 16'h0100, 8'h00, "R10");
    step(1, 0, 16'h8002, 8'h00, "R10");
    // R9 read data only after reads
    step(0, 0, 16'h0005, 8'h00, "R9");
    step(0, 1, 16'h6001, 8'h99, "R9");
    step(1, 0, 16'h6001, 8'h00, "R9");
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom_range(0, 5));
      a  = 16'($urandom);
      if (op == 5) a = {2'b10, a[13:0]};
      step(op == 1 || op == 3 || op == 5, op == 2 || op == 3 || op == 4,
           (op == 4) ? {1'b1, a[14:0]} : a, 8'($urandom), "R9");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule